// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. It has a write side and a read side, and each side has its own free-running clock. The two clocks may be one net, or they may be unrelated. Words enter on the write clock while both write enables are high. Words leave through a registered output on the read clock while both read enables are high. An output-enable input lets the read data lines float.

Each pointer crosses into the other clock domain as a Gray code through two flip-flop stages. The read side computes the empty and near-empty flags. The write side computes the full and near-full flags. The two near thresholds sit in an offset register. A load cycle writes that register from the data input instead of pushing a word. Both offsets start at 7.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low, and after it is released, both pointers are zero, `empty`=1, `full`=0, `almost_empty`=1, `almost_full`=0, the output register holds 0, and both offsets are 7. So 7 stored words still show `almost_empty`=1, and 8 stored words show 0.
- R2: A word is stored on a rising `wclk` edge only when `wen_a`=1, `wen_b`=1, `load`=0 and `full`=0. A write with a single enable high stores nothing.
- R3: On a rising `rclk` edge with `ren_a`=1, `ren_b`=1 and `empty`=0, the oldest word moves into the output register. Words come out in write order, and the register holds its value on every other edge.
- R4: The read side sees a write pointer that passed through two `rclk` stages. The write side sees a read pointer that passed through two `wclk` stages. With the clocks tied, a word written at edge E clears `empty` after edge E+2. `full`=1 when the write-side count equals DEPTH, and a write while full is dropped. Each synchronised pointer changes by at most one bit per clock.
- R5: A read request while `empty`=1 changes neither the read pointer nor the output register.
- R6: `almost_empty`=1 exactly when the read-side count is at most the near-empty offset.
- R7: `almost_full`=1 exactly when the write-side count is at least DEPTH minus the near-full offset.
- R8: A `wclk` edge with `load`=1 and both write enables high is a load cycle. It stores no word. The first of two consecutive load cycles writes the near-empty offset, and the second writes the near-full offset. Each offset takes the low min(log2 DEPTH, 9) bits of `din`. Any cycle that is not a load cycle returns the sequence to the near-empty offset.
- R9: `dout` is high impedance while `oe`=0, and it shows the output register while `oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wen_a | input | 1 | First write enable |
| wen_b | input | 1 | Second write enable |
| load | input | 1 | Selects the offset register for a write |
| din | input | 9 | Write data or offset value |
| ren_a | input | 1 | First read enable |
| ren_b | input | 1 | Second read enable |
| oe | input | 1 | Output enable for `dout` |
| dout | output | 9 | Read data, high impedance when `oe`=0 |
| empty | output | 1 | No word visible to the read side |
| full | output | 1 | DEPTH words as seen by the write side |
| almost_empty | output | 1 | Read-side count at or below the near-empty offset |
| almost_full | output | 1 | Write-side count at or above DEPTH minus the near-full offset |

## Verification
The assertions check the following on every edge:
- dropped writes on full, on a single enable and on load cycles leave the write pointer alone;
- dropped reads on empty freeze both the read pointer and the output register;
- each synchronised Gray pointer moves by at most one bit;
- the near flags always cover the matching end flags.

The bench's scenarios check the rest against a behavioural model with the clocks tied:
- the two-edge flag latency;
- data order through fill, drain and random traffic;
- the load sequence and the default offsets;
- the high-impedance output.

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             wen_a,
  input  logic             wen_b,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             ren_a,
  input  logic             ren_b,
  input  logic             oe,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic             almost_empty,
  output logic             almost_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int OW = (AW < WIDTH) ? AW : WIDTH;
  localparam logic [OW-1:0] DEF_OFF = OW'(7);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] q;
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] wg_s1, wg_s2, rg_s1, rg_s2;
  logic [PW-1:0] wbin_nx, rbin_nx, wcount, rcount;
  logic [OW-1:0] ae_off, af_off;
  logic ld_second;
  logic do_load, do_write, do_read;

  assign do_load  = wen_a & wen_b & load;
  assign do_write = wen_a & wen_b & ~load & ~full;
  assign do_read  = ren_a & ren_b & ~empty;
  assign wbin_nx  = wbin + PW'(do_write);
  assign rbin_nx  = rbin + PW'(do_read);

  always_ff @(posedge wclk)
    if (do_write) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin      <= '0;
      wgray     <= '0;
      rg_s1     <= '0;
      rg_s2     <= '0;
      ae_off    <= DEF_OFF;
      af_off    <= DEF_OFF;
      ld_second <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= to_gray(wbin_nx);
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (do_load) begin
        ld_second <= ~ld_second;
        if (ld_second) af_off <= din[OW-1:0];
        else           ae_off <= din[OW-1:0];
      end else begin
        ld_second <= 1'b0;
      end
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      q     <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= to_gray(rbin_nx);
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (do_read) q <= mem[rbin[AW-1:0]];
    end
  end

  assign rcount       = to_bin(wg_s2) - rbin;
  assign empty        = (rcount == '0);
  assign almost_empty = (rcount <= PW'(ae_off));
  assign wcount       = wbin - to_bin(rg_s2);
  assign full         = (wcount == DEPTH_P);
  assign almost_full  = (wcount >= DEPTH_P - PW'(af_off));
  assign dout         = oe ? q : 'z;

  p_single_enable_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen_a != wen_b) |=> $stable(wbin));
  p_no_overflow_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen_a && wen_b && full) |=> $stable(wbin));
  p_gray_step_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(wg_s2 ^ $past(wg_s2)) <= 1);
  p_no_underflow_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren_a && ren_b && empty) |=> ($stable(rbin) && $stable(q)));
  p_ae_covers_empty_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);
  p_af_covers_full_r7: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);
  p_load_no_write_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen_a && wen_b && load) |=> $stable(wbin));
endmodule

// File: tb/test_dcfifo_pflag.sv
module test_dcfifo_pflag;
  localparam int DEPTH = 256;
  localparam int OW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wen_a = 0, wen_b = 0, load = 0, ren_a = 0, ren_b = 0, oe = 1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic empty, full, almost_empty, almost_full;

  always #5 clk = ~clk;

  dcfifo_pflag #(.DEPTH(DEPTH), .WIDTH(9)) i_dcfifo_pflag (
    .wclk(clk), .rclk(clk), .rst_n(rst_n),
    .wen_a(wen_a), .wen_b(wen_b), .load(load), .din(din),
    .ren_a(ren_a), .ren_b(ren_b), .oe(oe), .dout(dout),
    .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full));

  int checks = 0, errors = 0;
  int wr_tot, rd_tot, ws1, ws2, rs1, rs2, ae_o, af_o;
  bit ph;
  logic [8:0] exp_q;
  logic [8:0] fifo_q[$];

  function automatic bit m_empty(); return ws2 == rd_tot; endfunction
  function automatic bit m_full(); return (wr_tot - rs2) == DEPTH; endfunction
  function automatic bit m_ae(); return (ws2 - rd_tot) <= ae_o; endfunction
  function automatic bit m_af(); return (wr_tot - rs2) >= DEPTH - af_o; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(empty == m_empty(), "R4 empty", empty, m_empty());
    chk(full == m_full(), "R4 full", full, m_full());
    chk(almost_empty == m_ae(), "R6 almost_empty", almost_empty, m_ae());
    chk(almost_full == m_af(), "R7 almost_full", almost_full, m_af());
    if (oe) chk(dout === exp_q, "R3 dout", dout, exp_q);
  endtask

  task automatic model_reset();
    wr_tot = 0; rd_tot = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
    ae_o = 7; af_o = 7; ph = 0; exp_q = '0;
    fifo_q.delete();
  endtask

  task automatic step(input bit wa, input bit wb, input bit ld,
                      input bit ra, input bit rb, input logic [8:0] d);
    bit we, le, re;
    @(negedge clk);
    compare();
    wen_a = wa; wen_b = wb; load = ld; ren_a = ra; ren_b = rb; din = d;
    we = wa && wb && !ld && !m_full();
    le = wa && wb && ld;
    re = ra && rb && !m_empty();
    if (re) exp_q = fifo_q.pop_front();
    if (we) fifo_q.push_back(d);
    if (le) begin
      if (ph) af_o = int'(d[OW-1:0]);
      else    ae_o = int'(d[OW-1:0]);
      ph = !ph;
    end else ph = 0;
    ws2 = ws1; ws1 = wr_tot; rs2 = rs1; rs1 = rd_tot;
    wr_tot += int'(we); rd_tot += int'(re);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wen_a = 0; wen_b = 0; load = 0; ren_a = 0; ren_b = 0; oe = 1;
    model_reset();
    repeat (2) @(negedge clk);
    chk(empty === 1'b1, "R1 empty", empty, 1);
    chk(full === 1'b0, "R1 full", full, 0);
    chk(almost_empty === 1'b1, "R1 almost_empty", almost_empty, 1);
    chk(almost_full === 1'b0, "R1 almost_full", almost_full, 0);
    chk(dout === 9'd0, "R1 dout", dout, 0);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [8:0] held;
    model_reset();
    do_reset();

    // R2: a single write enable stores nothing
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 9'h55);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 9'h66);
    idle(4);
    chk(empty === 1'b1, "R2 single enable", empty, 1);

    // R1: default near-empty offset of 7
    for (int i = 0; i < 7; i++) step(1, 1, 0, 0, 0, 9'(i * 3 + 1));
    idle(4);
    chk(almost_empty === 1'b1, "R1 default offset 7 words", almost_empty, 1);
    step(1, 1, 0, 0, 0, 9'h1FF);
    idle(4);
    chk(almost_empty === 1'b0, "R1 default offset 8 words", almost_empty, 0);

    // R3: drain, with reads interleaved with idles
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 1, 1, '0);
      if (i % 3 == 0) idle(1);
    end
    idle(4);

    // R5: reads on empty leave the output register alone
    @(negedge clk); held = dout;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, '0);
    idle(1);
    chk(dout === held, "R5 hold on empty read", dout, held);

    // R9: output enable low floats the output
    @(negedge clk); oe = 0; #1;
    chk(dout === 9'bz, "R9 high impedance", dout, 0);
    idle(2);
    oe = 1; #1;
    chk(dout === held, "R9 restored", dout, held);

    // R8: load near-empty = 3, then near-full = 5
    step(1, 1, 1, 0, 0, 9'd3);
    step(1, 1, 1, 0, 0, 9'd5);
    idle(4);
    chk(empty === 1'b1, "R8 load stores no word", empty, 1);
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 9'(100 + i));
    idle(4);
    chk(almost_empty === 1'b1, "R8 three words at offset 3", almost_empty, 1);
    step(1, 1, 0, 0, 0, 9'd200);
    idle(4);
    chk(almost_empty === 1'b0, "R8 four words above offset 3", almost_empty, 0);

    // R4, R7: fill past capacity, extra writes dropped
    for (int i = 0; i < DEPTH; i++) step(1, 1, 0, 0, 0, 9'(i * 7));
    idle(4);
    chk(full === 1'b1, "R4 full after fill", full, 1);
    chk(almost_full === 1'b1, "R7 near full", almost_full, 1);
    for (int i = 0; i < DEPTH + 6; i++) step(0, 0, 0, 1, 1, '0);
    idle(4);
    chk(empty === 1'b1, "R4 empty after drain", empty, 1);

    // mixed traffic with shifting bias
    for (int i = 0; i < 3000; i++) begin
      int bias;
      bit w, r;
      bias = (i / 500) % 3;
      w = ($urandom % 8) < (bias == 0 ? 7 : (bias == 1 ? 2 : 4));
      r = ($urandom % 8) < (bias == 0 ? 2 : (bias == 1 ? 7 : 4));
      step(w, w | ($urandom % 4 == 0), 0, r, r | ($urandom % 4 == 0), 9'($urandom));
    end

    // R1: reset in the middle of traffic
    do_reset();
    idle(3);
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule